// File: doc/BRIEF.md
# E1 Receive Alarm Monitor

This block watches a received E1 bit stream, one bit per clock on which a valid strobe is high. It runs a detector for each of three line alarms: loss of the received carrier, unframed all-ones (AIS), and the remote alarm indication carried in timeslot 0 of the frames without the alignment word. A fourth condition, loss of frame sync, comes in as a level from the framer. Each detector has its own rules for declaring and for clearing its alarm, based on windows or runs.

The four conditions appear as a real-time status vector. They also feed a latched event register. Before each read, the host writes a bit mask. Each position written 1 copies its latched value into the read port and is then cleared. Each position written 0 keeps both its read value and its latched value. An active-low interrupt stays asserted while any latched bit whose mask input is 1 is set. When automatic alarm generation is enabled, the block asks the transmitter to send AIS or a remote alarm whenever sync loss, received AIS or carrier loss is present. Bus decoding and line coding belong to other blocks.

The stream input has no back-pressure. The block takes every bit presented with `rx_valid` high and never stalls, so no ready signal exists. A clock with `rx_valid` low does not advance any window or run.

Top module: `e1_alarm_mon`

## Requirements
- R1: After reset, `rt_status` and `status_rdata` are 0, `irq_n` is 1, and `force_ais` and `force_ra` are 0. Status bit positions are: [0] frame sync loss, [1] carrier loss, [2] AIS, [3] remote alarm.
- R2: Carrier loss (bit 1) is declared on the 255th consecutive received zero. It becomes visible on the clock edge that takes that bit. 254 zeros in a row do not declare it.
- R3: While carrier loss is present, the received bits are grouped into windows of 255. The first window starts with the bit after the alarm was declared. At the last bit of a window, the alarm clears if the window held at least 32 ones; otherwise it stays set.
- R4: AIS (bit 2) is evaluated on back-to-back windows of 512 received bits, counted from reset. At the last bit of each window, AIS is set if the window held two or fewer zeros and cleared if it held more.
- R5: The remote alarm (bit 3) only looks at bits received with `rx_nas` high. It sets after three consecutive such bits equal to 1 and clears after three consecutive such bits equal to 0. Bits received with `rx_nas` low have no effect on it.
- R6: A latched bit is set on every clock on which its real-time condition is 1. It stays set until the host clears it.
- R7: A write with `status_wr` high loads `status_rdata[i]` with the latched bit and clears that latched bit, for each i with `status_wdata[i]`=1. Where `status_wdata[i]`=0, both `status_rdata[i]` and the latched bit are left unchanged. The new read value appears one clock after the write.
- R8: If a condition is active on the same clock as a host clear of its bit, the latched bit stays set.
- R9: `irq_n` is 0 exactly while some latched bit is set whose `int_mask` bit is 1. A mask bit of 0 masks that bit.
- R10: `force_ais` equals `auto_ais_en` AND (sync loss OR AIS OR carrier loss). `force_ra` equals `auto_ra_en` AND the same fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | A received bit is present this clock |
| rx_bit | input | 1 | Received bit value |
| rx_nas | input | 1 | This bit is the remote-alarm position of a non-alignment timeslot 0 |
| los_sync | input | 1 | Frame sync loss from the framer |
| status_wr | input | 1 | Host write of the read/clear mask |
| status_wdata | input | 4 | Read/clear mask |
| status_rdata | output | 4 | Latched values captured by the last writes |
| int_mask | input | 4 | Per-bit interrupt enable, 1 = enabled |
| irq_n | output | 1 | Active-low interrupt |
| rt_status | output | 4 | Real-time alarm conditions |
| auto_ais_en | input | 1 | Request AIS transmission on receive fault |
| auto_ra_en | input | 1 | Request remote alarm transmission on receive fault |
| force_ais | output | 1 | Transmit AIS request |
| force_ra | output | 1 | Transmit remote alarm request |

## Verification
The assertions assume that every input holds a known value from the first clock. They also assume that `rx_nas` has meaning only when `rx_valid` is high, so that each alarm change can be traced back to a received bit of the right kind. The bench drives every input from time zero and changes inputs only on the falling edge. It raises `rx_nas` only together with `rx_valid`. Each scenario begins with a fresh reset, so the AIS windows line up with the bit counts the bench keeps.

// File: rtl/e1_alarm_pkg.sv
package e1_alarm_pkg;
  localparam int N_ALM       = 4;
  localparam int IDX_SYNC    = 0;
  localparam int IDX_CARRIER = 1;
  localparam int IDX_AIS     = 2;
  localparam int IDX_RAI     = 3;
endpackage

// File: rtl/e1_carrier_mon.sv
module e1_carrier_mon #(
  parameter int RUN_LEN  = 255,
  parameter int WIN_LEN  = 255,
  parameter int ONES_MIN = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_vld,
  input  logic bit_val,
  output logic loss
);
  localparam int RW = $clog2(RUN_LEN + 1);
  localparam int WW = $clog2(WIN_LEN + 1);

  logic [RW-1:0] zrun;
  logic [WW-1:0] wcnt;
  logic [WW-1:0] ones;
  logic [WW-1:0] ones_nxt;

  assign ones_nxt = ones + WW'(bit_val);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      loss <= 1'b0;
      zrun <= '0;
      wcnt <= '0;
      ones <= '0;
    end else if (bit_vld) begin
      if (!loss) begin
        // searching for a long run of zeros
        wcnt <= '0;
        ones <= '0;
        if (bit_val) begin
          zrun <= '0;
        end else if (zrun == RW'(RUN_LEN - 1)) begin
          loss <= 1'b1;
          zrun <= '0;
        end else begin
          zrun <= zrun + 1'b1;
        end
      end else begin
        // in alarm: density check per fixed window
        zrun <= '0;
        if (wcnt == WW'(WIN_LEN - 1)) begin
          if (ones_nxt >= WW'(ONES_MIN)) loss <= 1'b0;
          wcnt <= '0;
          ones <= '0;
        end else begin
          wcnt <= wcnt + 1'b1;
          ones <= ones_nxt;
        end
      end
    end
  end
endmodule

// File: rtl/e1_ais_mon.sv
module e1_ais_mon #(
  parameter int WIN_LEN   = 512,
  parameter int MAX_ZEROS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_vld,
  input  logic bit_val,
  output logic ais
);
  localparam int WW = $clog2(WIN_LEN);
  localparam int ZW = $clog2(MAX_ZEROS + 2);

  logic [WW-1:0] wcnt;
  logic [ZW-1:0] zcnt;
  logic [ZW-1:0] zcnt_nxt;

  // zero count saturates one above the limit
  assign zcnt_nxt = (!bit_val && (zcnt != ZW'(MAX_ZEROS + 1))) ? zcnt + 1'b1 : zcnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ais  <= 1'b0;
      wcnt <= '0;
      zcnt <= '0;
    end else if (bit_vld) begin
      if (wcnt == WW'(WIN_LEN - 1)) begin
        ais  <= (zcnt_nxt <= ZW'(MAX_ZEROS));
        wcnt <= '0;
        zcnt <= '0;
      end else begin
        wcnt <= wcnt + 1'b1;
        zcnt <= zcnt_nxt;
      end
    end
  end
endmodule

// File: rtl/e1_rai_mon.sv
module e1_rai_mon #(
  parameter int RUN_LEN = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe,
  input  logic bit_val,
  output logic rai
);
  localparam int CW = $clog2(RUN_LEN + 1);

  logic [CW-1:0] run;

  // counts consecutive samples that disagree with the current state
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rai <= 1'b0;
      run <= '0;
    end else if (strobe) begin
      if (bit_val == rai) begin
        run <= '0;
      end else if (run == CW'(RUN_LEN - 1)) begin
        rai <= ~rai;
        run <= '0;
      end else begin
        run <= run + 1'b1;
      end
    end
  end
endmodule

// File: rtl/e1_status_latch.sv
module e1_status_latch #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] event_in,
  input  logic         wr,
  input  logic [N-1:0] wmask,
  input  logic [N-1:0] int_mask,
  output logic [N-1:0] latched,
  output logic [N-1:0] rdata,
  output logic         irq_n
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic sel;
    assign sel = wr & wmask[i];
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        latched[i] <= 1'b0;
        rdata[i]   <= 1'b0;
      end else begin
        latched[i] <= event_in[i] | (latched[i] & ~sel);
        if (sel) rdata[i] <= latched[i];
      end
    end
  end

  assign irq_n = ~|(latched & int_mask);
endmodule

// File: rtl/e1_alarm_mon.sv
module e1_alarm_mon
  import e1_alarm_pkg::*;
#(
  parameter int RCL_RUN   = 255,
  parameter int RCL_WIN   = 255,
  parameter int RCL_ONES  = 32,
  parameter int AIS_WIN   = 512,
  parameter int AIS_ZEROS = 2,
  parameter int RAI_RUN   = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_valid,
  input  logic             rx_bit,
  input  logic             rx_nas,
  input  logic             los_sync,
  input  logic             status_wr,
  input  logic [N_ALM-1:0] status_wdata,
  output logic [N_ALM-1:0] status_rdata,
  input  logic [N_ALM-1:0] int_mask,
  output logic             irq_n,
  output logic [N_ALM-1:0] rt_status,
  input  logic             auto_ais_en,
  input  logic             auto_ra_en,
  output logic             force_ais,
  output logic             force_ra
);
  logic carrier_loss, ais_det, rai_det, rx_fault;
  logic [N_ALM-1:0] latched_q;

  e1_carrier_mon #(.RUN_LEN(RCL_RUN), .WIN_LEN(RCL_WIN), .ONES_MIN(RCL_ONES)) u_carrier (
    .clk(clk), .rst_n(rst_n), .bit_vld(rx_valid), .bit_val(rx_bit), .loss(carrier_loss));

  e1_ais_mon #(.WIN_LEN(AIS_WIN), .MAX_ZEROS(AIS_ZEROS)) u_ais (
    .clk(clk), .rst_n(rst_n), .bit_vld(rx_valid), .bit_val(rx_bit), .ais(ais_det));

  e1_rai_mon #(.RUN_LEN(RAI_RUN)) u_rai (
    .clk(clk), .rst_n(rst_n), .strobe(rx_valid & rx_nas), .bit_val(rx_bit), .rai(rai_det));

  always_comb begin
    rt_status              = '0;
    rt_status[IDX_SYNC]    = los_sync;
    rt_status[IDX_CARRIER] = carrier_loss;
    rt_status[IDX_AIS]     = ais_det;
    rt_status[IDX_RAI]     = rai_det;
  end

  e1_status_latch #(.N(N_ALM)) u_latch (
    .clk(clk), .rst_n(rst_n), .event_in(rt_status), .wr(status_wr),
    .wmask(status_wdata), .int_mask(int_mask), .latched(latched_q),
    .rdata(status_rdata), .irq_n(irq_n));

  assign rx_fault  = los_sync | carrier_loss | ais_det;
  assign force_ais = auto_ais_en & rx_fault;
  assign force_ra  = auto_ra_en & rx_fault;
endmodule

// File: rtl/e1_alarm_mon_chk.sv
module e1_alarm_mon_chk
  import e1_alarm_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             rx_valid,
  input logic             rx_bit,
  input logic             rx_nas,
  input logic             status_wr,
  input logic [N_ALM-1:0] status_wdata,
  input logic [N_ALM-1:0] status_rdata,
  input logic [N_ALM-1:0] rt_status,
  input logic [N_ALM-1:0] latched_q,
  input logic             auto_ais_en,
  input logic             auto_ra_en,
  input logic             force_ais,
  input logic             force_ra
);
  assert_latch_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rt_status != '0) |=> ((latched_q & $past(rt_status)) == $past(rt_status)));

  assert_snapshot_R7: assert property (@(posedge clk) disable iff (!rst_n)
    status_wr |=> (status_rdata == (($past(status_wdata) & $past(latched_q)) |
                                    (~$past(status_wdata) & $past(status_rdata)))));

  assert_carrier_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rt_status[IDX_CARRIER]) |-> $past(rx_valid && !rx_bit));

  assert_ais_steady_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rx_valid) |-> $stable(rt_status[IDX_AIS]));

  assert_rai_steady_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rx_valid && rx_nas) |-> $stable(rt_status[IDX_RAI]));

  assert_force_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!auto_ais_en |-> !force_ais) and (!auto_ra_en |-> !force_ra));
endmodule

bind e1_alarm_mon e1_alarm_mon_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_bit(rx_bit), .rx_nas(rx_nas),
  .status_wr(status_wr), .status_wdata(status_wdata), .status_rdata(status_rdata),
  .rt_status(rt_status), .latched_q(latched_q), .auto_ais_en(auto_ais_en),
  .auto_ra_en(auto_ra_en), .force_ais(force_ais), .force_ra(force_ra));

// File: tb/e1_alarm_mon_test.sv
module e1_alarm_mon_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_valid = 1'b0, rx_bit = 1'b0, rx_nas = 1'b0, los_sync = 1'b0;
  logic       status_wr = 1'b0;
  logic [3:0] status_wdata = '0, int_mask = '0;
  logic       auto_ais_en = 1'b0, auto_ra_en = 1'b0;
  logic [3:0] status_rdata, rt_status;
  logic       irq_n, force_ais, force_ra;
  int         n_chk = 0, n_fail = 0;
  bit         done = 1'b0;

  always #10 clk = ~clk;

  e1_alarm_mon uut (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_bit(rx_bit), .rx_nas(rx_nas),
    .los_sync(los_sync), .status_wr(status_wr), .status_wdata(status_wdata),
    .status_rdata(status_rdata), .int_mask(int_mask), .irq_n(irq_n),
    .rt_status(rt_status), .auto_ais_en(auto_ais_en), .auto_ra_en(auto_ra_en),
    .force_ais(force_ais), .force_ra(force_ra));

  task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rx_valid = 0; rx_bit = 0; rx_nas = 0; los_sync = 0; status_wr = 0;
    status_wdata = '0; int_mask = '0; auto_ais_en = 0; auto_ra_en = 0;
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic send_bits(input int n, input logic b, input logic nas);
    for (int i = 0; i < n; i++) begin
      rx_valid = 1; rx_bit = b; rx_nas = nas;
      @(negedge clk);
    end
    rx_valid = 0; rx_nas = 0;
  endtask

  task automatic host_write(input logic [3:0] m);
    status_wr = 1; status_wdata = m;
    @(negedge clk);
    status_wr = 0; status_wdata = '0;
  endtask

  task automatic test_reset();
    do_reset();
    chk("R1 rt_status", rt_status, 4'h0);
    chk("R1 rdata", status_rdata, 4'h0);
    chk("R1 irq_n/force", {1'b0, irq_n, force_ais, force_ra}, 4'b0100);
  endtask

  task automatic test_carrier();
    do_reset();
    auto_ais_en = 1;
    send_bits(254, 0, 0);
    chk("R2 no loss at 254 zeros", {3'b0, rt_status[1]}, 4'h0);
    send_bits(1, 0, 0);
    chk("R2 loss at 255 zeros", {3'b0, rt_status[1]}, 4'h1);
    chk("R10 force_ais/force_ra", {2'b0, force_ais, force_ra}, 4'b0010);
    send_bits(31, 1, 0);
    send_bits(224, 0, 0);
    chk("R3 held with 31 ones", {3'b0, rt_status[1]}, 4'h1);
    send_bits(32, 1, 0);
    send_bits(222, 0, 0);
    chk("R3 held before window end", {3'b0, rt_status[1]}, 4'h1);
    send_bits(1, 0, 0);
    chk("R3 cleared with 32 ones", {3'b0, rt_status[1]}, 4'h0);
  endtask

  task automatic test_ais();
    do_reset();
    send_bits(511, 1, 0);
    chk("R4 not set before window end", {3'b0, rt_status[2]}, 4'h0);
    send_bits(1, 1, 0);
    chk("R4 set on all ones", {3'b0, rt_status[2]}, 4'h1);
    @(negedge clk);
    host_write(4'b0100);
    chk("R6 R7 latched AIS read", status_rdata, 4'b0100);
    send_bits(3, 0, 0);
    send_bits(509, 1, 0);
    chk("R4 cleared on 3 zeros", {3'b0, rt_status[2]}, 4'h0);
    send_bits(2, 0, 0);
    send_bits(510, 1, 0);
    chk("R4 set on 2 zeros", {3'b0, rt_status[2]}, 4'h1);
  endtask

  task automatic test_rai();
    do_reset();
    send_bits(2, 1, 1);
    chk("R5 not set after two ones", {3'b0, rt_status[3]}, 4'h0);
    send_bits(1, 1, 1);
    chk("R5 set after three ones", {3'b0, rt_status[3]}, 4'h1);
    send_bits(5, 0, 0);
    chk("R5 non-marked zeros ignored", {3'b0, rt_status[3]}, 4'h1);
    send_bits(2, 0, 1);
    send_bits(1, 1, 1);
    send_bits(2, 0, 1);
    chk("R5 run restarted by a one", {3'b0, rt_status[3]}, 4'h1);
    send_bits(1, 0, 1);
    chk("R5 cleared after three zeros", {3'b0, rt_status[3]}, 4'h0);
  endtask

  task automatic test_latch();
    do_reset();
    auto_ra_en = 1;
    los_sync = 1;
    @(negedge clk);
    chk("R10 force_ra on sync loss", {2'b0, force_ais, force_ra}, 4'b0001);
    los_sync = 0;
    @(negedge clk);
    chk("R9 masked irq", {3'b0, irq_n}, 4'h1);
    int_mask = 4'b0001;
    #1;
    chk("R9 enabled irq", {3'b0, irq_n}, 4'h0);
    host_write(4'b1110);
    chk("R7 mask 0 leaves rdata", status_rdata, 4'h0);
    chk("R7 mask 0 keeps latched", {3'b0, irq_n}, 4'h0);
    host_write(4'b0001);
    chk("R7 read returns latched", status_rdata, 4'b0001);
    chk("R7 clear releases irq", {3'b0, irq_n}, 4'h1);
    host_write(4'b0001);
    chk("R7 second read is clear", status_rdata, 4'h0);
    los_sync = 1;
    @(negedge clk);
    host_write(4'b0001);
    chk("R8 read while active", status_rdata, 4'b0001);
    chk("R8 bit stays latched", {3'b0, irq_n}, 4'h0);
    los_sync = 0;
    @(negedge clk);
    host_write(4'b0001);
    host_write(4'b0001);
    chk("R6 cleared after condition ends", status_rdata, 4'h0);
  endtask

  initial begin
    test_reset();
    test_carrier();
    test_ais();
    test_rai();
    test_latch();
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 150000 && !done; c++) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule